// File: doc/BRIEF.md
# Power-Fail and Reset-Cause Flag Register

This block is a register slice that keeps two supply-related facts for the processor. The first is a sticky indicator that the most recent reset came from power-on. The second is a power-fail event flag, with its enable, that turns a supply-low comparator output into an interrupt request. Software reads the three bits through a byte-wide read port and changes them through a byte-wide write port. Both ports use single-cycle strobes.

The power-on indicator is set only by the power-on reset, and every other reset leaves it alone. Software can clear it only when the write arrives in the same cycle as a timed-access unlock pulse. The supply-low input is asynchronous, so it passes through a synchronizer before its rising edge sets the power-fail flag. The flag stays set until software clears it. While it stays set with the enable on, the interrupt request stays asserted. In stop mode the request also needs the bandgap-select input.

Top module: `pwr_status_slice`

## Requirements
- R1: A power-on reset (`por_i` high at a clock edge) sets the power-on flag to 1 at that edge.
- R2: A system reset (`sys_rst_i` high, `por_i` low) leaves the power-on flag at its previous value.
- R3: A write clears the power-on flag only when `ta_unlock_i` is high in the same cycle and write-data bit 2 is 0. Plain writes do not change it, and writing 1 never sets it.
- R4: The interrupt request `pf_irq_o` is 0 whenever the power-fail enable (register bit 0) is 0.
- R5: While `stop_mode_i` is 1, `pf_irq_o` is 0 unless `bg_sel_i` is also 1.
- R6: A rising edge on `supply_low_i` sets the power-fail flag (register bit 1) on the third clock edge after the input rises. The flag then stays 1 until a write puts 0 in bit 1.
- R7: As long as the flag and the enable are both 1, and the stop-mode condition of R5 is met, `pf_irq_o` stays 1 on every cycle.
- R8: A write with bit 1 set to 1 sets the power-fail flag, and the flag raises `pf_irq_o` if the write also enables it.
- R9: Either reset clears the power-fail enable and the power-fail flag to 0.
- R10: With `rd_en_i` high, `rd_data_o` shows enable in bit 0, flag in bit 1 and power-on flag in bit 2, with the other bits 0. With `rd_en_i` low, `rd_data_o` is 0.
- R11: If a synchronized supply-low edge and a write of 0 to bit 1 fall in the same cycle, the flag ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_i | input | 1 | Power-on reset, active high, synchronous |
| sys_rst_i | input | 1 | Any other reset, active high, synchronous |
| supply_low_i | input | 1 | Asynchronous supply-low comparator output |
| stop_mode_i | input | 1 | Core is in stop mode |
| bg_sel_i | input | 1 | Bandgap reference selected during stop |
| ta_unlock_i | input | 1 | Timed-access unlock pulse, qualifies a same-cycle write |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_en_i | input | 1 | Register read strobe |
| rd_data_o | output | 8 | Register read data |
| pwr_on_flag_o | output | 1 | Power-on reset flag |
| pf_en_o | output | 1 | Power-fail interrupt enable |
| pf_flag_o | output | 1 | Power-fail flag |
| pf_irq_o | output | 1 | Power-fail interrupt request |

## Verification
Directed sequences cover each protected-write case: an unlocked clear, a plain write of 0, and an unlocked write of 1. These show whether the unlock actually guards the power-on flag, and the system reset versus power-on reset sequences show which reset touches it. Directed checks also sweep the stop-mode and bandgap-select combinations with the flag set and the enable set or clear. The supply-low edge is timed against the synchronizer cycle by cycle, and one case puts that edge in the same cycle as a clearing write. A long seeded random run then mixes both resets, locked and unlocked writes, supply-low toggles and stop-mode changes, and compares every output against a cycle model each cycle.

// File: rtl/pss_pkg.sv
package pss_pkg;
   typedef struct packed {
      logic pwr_on;
      logic pf_flag;
      logic pf_en;
   } pss_state_t;

   localparam int unsigned PSS_MIN_SYNC = 2;
endpackage

// File: rtl/pss_sync.sv
module pss_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic d_i,
   output logic q_o
);
   localparam int unsigned LAST = STAGES - 1;

   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < pss_pkg::PSS_MIN_SYNC) begin : g_bad
         $error("pss_sync: STAGES below minimum");
      end
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk_i) begin
            if (rst_i) chain_q <= '0;
            else       chain_q <= d_i;
         end
      end else begin : g_multi
         always_ff @(posedge clk_i) begin
            if (rst_i) chain_q <= '0;
            else       chain_q <= {chain_q[STAGES-2:0], d_i};
         end
      end
   endgenerate

   assign q_o = chain_q[LAST];
endmodule

// File: rtl/pss_flags.sv
module pss_flags (
   input  logic                 clk_i,
   input  logic                 por_i,
   input  logic                 sys_rst_i,
   input  logic                 low_sync_i,
   input  logic                 wr_en_i,
   input  logic                 ta_unlock_i,
   input  logic                 wd_en_i,
   input  logic                 wd_flag_i,
   input  logic                 wd_pon_i,
   output pss_pkg::pss_state_t  state_o
);
   import pss_pkg::*;

   logic       low_prev_q;
   logic       low_rise;
   pss_state_t st_q;

   assign low_rise = low_sync_i & ~low_prev_q;

   always_ff @(posedge clk_i) begin
      if (por_i || sys_rst_i) low_prev_q <= 1'b0;
      else                    low_prev_q <= low_sync_i;
   end

   // power-on flag: only power-on reset sets it, only an unlocked write clears it
   always_ff @(posedge clk_i) begin
      if (por_i)
         st_q.pwr_on <= 1'b1;
      else if (!sys_rst_i && wr_en_i && ta_unlock_i && !wd_pon_i)
         st_q.pwr_on <= 1'b0;
   end

   // enable and event flag: cleared by any reset; a hardware edge wins over a clearing write
   always_ff @(posedge clk_i) begin
      if (por_i || sys_rst_i) begin
         st_q.pf_en   <= 1'b0;
         st_q.pf_flag <= 1'b0;
      end else if (wr_en_i) begin
         st_q.pf_en   <= wd_en_i;
         st_q.pf_flag <= wd_flag_i | low_rise;
      end else if (low_rise) begin
         st_q.pf_flag <= 1'b1;
      end
   end

   assign state_o = st_q;
endmodule

// File: rtl/pss_irq.sv
module pss_irq #(
   parameter bit STOP_NEEDS_BG = 1'b1
) (
   input  logic flag_i,
   input  logic en_i,
   input  logic stop_i,
   input  logic bg_sel_i,
   output logic irq_o
);
   logic ref_ok;

   generate
      if (STOP_NEEDS_BG) begin : g_gate
         assign ref_ok = ~stop_i | bg_sel_i;
      end else begin : g_nogate
         logic unused_gate;
         assign unused_gate = stop_i ^ bg_sel_i;
         assign ref_ok = 1'b1;
      end
   endgenerate

   assign irq_o = flag_i & en_i & ref_ok;
endmodule

// File: rtl/pwr_status_slice.sv
module pwr_status_slice #(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned EN_BIT      = 0,
   parameter int unsigned FLAG_BIT    = 1,
   parameter int unsigned PON_BIT     = 2,
   parameter bit          RDATA_REG   = 1'b0,
   parameter bit          STOP_GATE   = 1'b1
) (
   input  logic              clk_i,
   input  logic              por_i,
   input  logic              sys_rst_i,
   input  logic              supply_low_i,
   input  logic              stop_mode_i,
   input  logic              bg_sel_i,
   input  logic              ta_unlock_i,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              rd_en_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              pwr_on_flag_o,
   output logic              pf_en_o,
   output logic              pf_flag_o,
   output logic              pf_irq_o
);
   import pss_pkg::*;

   localparam int unsigned MAX_BIT = (EN_BIT > FLAG_BIT) ?
                                     ((EN_BIT > PON_BIT) ? EN_BIT : PON_BIT) :
                                     ((FLAG_BIT > PON_BIT) ? FLAG_BIT : PON_BIT);

   generate
      if (MAX_BIT >= DATA_W) begin : g_bad_pos
         $error("pwr_status_slice: field position outside data width");
      end
      if (EN_BIT == FLAG_BIT || EN_BIT == PON_BIT || FLAG_BIT == PON_BIT) begin : g_bad_overlap
         $error("pwr_status_slice: field positions overlap");
      end
   endgenerate

   logic       rst_any;
   logic       low_sync;
   pss_state_t st;
   logic [DATA_W-1:0] rd_view;

   assign rst_any = por_i | sys_rst_i;

   pss_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_i (rst_any),
      .d_i   (supply_low_i),
      .q_o   (low_sync)
   );

   pss_flags u_flags (
      .clk_i       (clk_i),
      .por_i       (por_i),
      .sys_rst_i   (sys_rst_i),
      .low_sync_i  (low_sync),
      .wr_en_i     (wr_en_i),
      .ta_unlock_i (ta_unlock_i),
      .wd_en_i     (wr_data_i[EN_BIT]),
      .wd_flag_i   (wr_data_i[FLAG_BIT]),
      .wd_pon_i    (wr_data_i[PON_BIT]),
      .state_o     (st)
   );

   pss_irq #(.STOP_NEEDS_BG(STOP_GATE)) u_irq (
      .flag_i   (st.pf_flag),
      .en_i     (st.pf_en),
      .stop_i   (stop_mode_i),
      .bg_sel_i (bg_sel_i),
      .irq_o    (pf_irq_o)
   );

   always_comb begin
      rd_view           = '0;
      rd_view[EN_BIT]   = st.pf_en;
      rd_view[FLAG_BIT] = st.pf_flag;
      rd_view[PON_BIT]  = st.pwr_on;
   end

   generate
      if (RDATA_REG) begin : g_rd_reg
         logic [DATA_W-1:0] rd_q;
         always_ff @(posedge clk_i) begin
            if (rst_any)      rd_q <= '0;
            else if (rd_en_i) rd_q <= rd_view;
            else              rd_q <= '0;
         end
         assign rd_data_o = rd_q;
      end else begin : g_rd_comb
         assign rd_data_o = rd_en_i ? rd_view : '0;
      end
   endgenerate

   assign pwr_on_flag_o = st.pwr_on;
   assign pf_en_o       = st.pf_en;
   assign pf_flag_o     = st.pf_flag;
endmodule

// File: rtl/pss_checker.sv
module pss_checker (
   input logic clk_i,
   input logic por_i,
   input logic sys_rst_i,
   input logic wr_en_i,
   input logic ta_unlock_i,
   input logic stop_mode_i,
   input logic bg_sel_i,
   input logic pwr_on_flag_o,
   input logic pf_en_o,
   input logic pf_flag_o,
   input logic pf_irq_o
);
   logic started_q = 1'b0;
   always_ff @(posedge clk_i) if (por_i) started_q <= 1'b1;

   a_r1_por_sets: assert property (@(posedge clk_i)
      por_i |=> pwr_on_flag_o);

   a_r2_sysrst_keeps: assert property (@(posedge clk_i) disable iff (por_i || !started_q)
      sys_rst_i |=> $stable(pwr_on_flag_o));

   a_r3_locked_write: assert property (@(posedge clk_i) disable iff (por_i || sys_rst_i || !started_q)
      (wr_en_i && !ta_unlock_i) |=> $stable(pwr_on_flag_o));

   a_r3_never_set: assert property (@(posedge clk_i) disable iff (por_i || !started_q)
      !pwr_on_flag_o |=> !pwr_on_flag_o);

   a_r4_needs_enable: assert property (@(posedge clk_i) disable iff (por_i || sys_rst_i || !started_q)
      !pf_en_o |-> !pf_irq_o);

   a_r5_stop_gate: assert property (@(posedge clk_i) disable iff (por_i || sys_rst_i || !started_q)
      (stop_mode_i && !bg_sel_i) |-> !pf_irq_o);

   a_r6_flag_sticky: assert property (@(posedge clk_i) disable iff (por_i || sys_rst_i || !started_q)
      (pf_flag_o && !wr_en_i) |=> pf_flag_o);

   a_r7_irq_held: assert property (@(posedge clk_i) disable iff (por_i || sys_rst_i || !started_q)
      (pf_flag_o && pf_en_o && (!stop_mode_i || bg_sel_i)) |-> pf_irq_o);

   a_r9_reset_clears: assert property (@(posedge clk_i) disable iff (!started_q && !por_i)
      (por_i || sys_rst_i) |=> (!pf_en_o && !pf_flag_o));
endmodule

bind pwr_status_slice pss_checker u_pss_checker (
   .clk_i         (clk_i),
   .por_i         (por_i),
   .sys_rst_i     (sys_rst_i),
   .wr_en_i       (wr_en_i),
   .ta_unlock_i   (ta_unlock_i),
   .stop_mode_i   (stop_mode_i),
   .bg_sel_i      (bg_sel_i),
   .pwr_on_flag_o (pwr_on_flag_o),
   .pf_en_o       (pf_en_o),
   .pf_flag_o     (pf_flag_o),
   .pf_irq_o      (pf_irq_o)
);

// File: tb/tb_pwr_status_slice.sv
`timescale 1ns/1ps
module tb_pwr_status_slice;
   logic       clk = 1'b0;
   logic       por = 1'b0, sys_rst = 1'b0, low = 1'b0, stop = 1'b0, bg = 1'b0;
   logic       ta = 1'b0, wr = 1'b0, rd = 1'b0;
   logic [7:0] wd = 8'h00;
   logic [7:0] rdata;
   logic       pon, en, flag, irq;
   int         checks = 0, errors = 0;
   bit         done = 1'b0;

   always #10 clk = ~clk;

   pwr_status_slice dut (
      .clk_i(clk), .por_i(por), .sys_rst_i(sys_rst), .supply_low_i(low),
      .stop_mode_i(stop), .bg_sel_i(bg), .ta_unlock_i(ta), .wr_en_i(wr),
      .wr_data_i(wd), .rd_en_i(rd), .rd_data_o(rdata),
      .pwr_on_flag_o(pon), .pf_en_o(en), .pf_flag_o(flag), .pf_irq_o(irq)
   );

   function automatic logic f_irq(logic f, logic e, logic s, logic b);
      return f & e & (~s | b);
   endfunction

   function automatic logic [7:0] f_rd(logic r, logic p, logic f, logic e);
      return r ? {5'b0, p, f, e} : 8'h00;
   endfunction

   task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr_reg(logic [7:0] d, logic unlock);
      wr = 1'b1; wd = d; ta = unlock;
      step();
      wr = 1'b0; ta = 1'b0; wd = 8'h00;
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      por = 1'b1; step(); por = 1'b0;
      rd = 1'b1; #1;
      chk("R1 power-on flag after por", {7'b0, pon}, 8'h01);
      chk("R9 enable/flag after por", {6'b0, en, flag}, 8'h00);
      chk("R10 readback after por", rdata, 8'h04);
      rd = 1'b0; #1;
      chk("R10 read strobe low", rdata, 8'h00);

      wr_reg(8'h00, 1'b0);
      chk("R3 plain write ignored", {7'b0, pon}, 8'h01);

      sys_rst = 1'b1; step(); sys_rst = 1'b0;
      chk("R2 sys reset keeps power-on flag", {7'b0, pon}, 8'h01);

      wr_reg(8'h00, 1'b1);
      chk("R3 unlocked clear", {7'b0, pon}, 8'h00);
      wr_reg(8'h04, 1'b1);
      chk("R3 write 1 does not set", {7'b0, pon}, 8'h00);
      sys_rst = 1'b1; step(); sys_rst = 1'b0;
      chk("R2 sys reset keeps cleared flag", {7'b0, pon}, 8'h00);
      por = 1'b1; step(); por = 1'b0;
      chk("R1 por sets again", {7'b0, pon}, 8'h01);

      wr_reg(8'h02, 1'b0);
      #1;
      chk("R8 software set flag", {7'b0, flag}, 8'h01);
      chk("R4 no irq while disabled", {7'b0, irq}, 8'h00);
      wr_reg(8'h03, 1'b0);
      #1;
      chk("R8 software set raises irq", {7'b0, irq}, 8'h01);
      for (int i = 0; i < 5; i++) step();
      #1;
      chk("R7 irq held while flag set", {7'b0, irq}, 8'h01);

      for (int s = 0; s < 2; s++) begin
         for (int b = 0; b < 2; b++) begin
            stop = s[0]; bg = b[0]; #1;
            chk("R5 stop/bandgap gating", {7'b0, irq}, {7'b0, f_irq(1'b1, 1'b1, s[0], b[0])});
         end
      end
      stop = 1'b0; bg = 1'b0;

      wr_reg(8'h01, 1'b0);
      #1;
      chk("R6 software clear", {6'b0, flag, irq}, 8'h00);

      low = 1'b1; step(); step();
      chk("R6 flag not yet set", {7'b0, flag}, 8'h00);
      step();
      chk("R6 flag set third edge", {7'b0, flag}, 8'h01);
      low = 1'b0;
      for (int i = 0; i < 4; i++) step();
      chk("R6 flag sticky", {7'b0, flag}, 8'h01);
      wr_reg(8'h01, 1'b0);
      chk("R6 cleared by write", {7'b0, flag}, 8'h00);

      low = 1'b1; step(); step();
      wr_reg(8'h01, 1'b0);
      chk("R11 edge wins over clear", {6'b0, en, flag}, 8'h03);
      low = 1'b0;
      for (int i = 0; i < 4; i++) step();

      begin
         logic mp, me, mf, q0, q1, q2, edge_v;
         void'($urandom(32'h5eed_1234));
         por = 1'b1; step(); por = 1'b0;
         mp = 1'b1; me = 1'b0; mf = 1'b0; q0 = 1'b0; q1 = 1'b0; q2 = 1'b0;
         for (int c = 0; c < 4000; c++) begin
            chk("R1 R2 R3 power-on flag model", {7'b0, pon}, {7'b0, mp});
            chk("R6 R8 R9 R11 flag/enable model", {6'b0, en, flag}, {6'b0, me, mf});
            por     = ($urandom_range(0, 299) == 0);
            sys_rst = ($urandom_range(0, 59) == 0);
            wr      = ($urandom_range(0, 3) == 0);
            ta      = ($urandom_range(0, 2) == 0);
            wd      = 8'($urandom);
            rd      = $urandom_range(0, 1);
            stop    = $urandom_range(0, 1);
            bg      = $urandom_range(0, 1);
            if ($urandom_range(0, 7) == 0) low = ~low;
            #1;
            chk("R4 R5 R7 irq model", {7'b0, irq}, {7'b0, f_irq(mf, me, stop, bg)});
            chk("R10 readback model", rdata, f_rd(rd, mp, mf, me));
            if (por) begin
               mp = 1'b1; me = 1'b0; mf = 1'b0; q0 = 1'b0; q1 = 1'b0; q2 = 1'b0;
            end else if (sys_rst) begin
               me = 1'b0; mf = 1'b0; q0 = 1'b0; q1 = 1'b0; q2 = 1'b0;
            end else begin
               edge_v = q1 & ~q2;
               if (wr) begin
                  me = wd[0];
                  mf = wd[1] | edge_v;
                  if (ta && !wd[2]) mp = 1'b0;
               end else if (edge_v) begin
                  mf = 1'b1;
               end
               q2 = q1; q1 = q0; q0 = low;
            end
            step();
         end
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule